// File: doc/BRIEF.md
# Planar Read Path with Colour Compare

This block sits on the host read side of a display controller whose memory is split into several bit planes. When the host issues a read, the block copies the full word fetched from display memory into a holding latch. The latch is kept for the write side, which later merges new data with it.

In the same cycle the block forms the single byte that goes back to the host. In plane mode it hands back the raw byte of one plane, chosen by a map index. In match mode it produces a mask with one bit per pixel. A mask bit is set when that pixel's multi-plane colour agrees with a reference colour. Planes that are flagged as "don't care" are left out of that agreement.

The latch and the host byte are both registered and change only on a read strobe. Memory addressing is handled elsewhere.

Top module: `gcr_read_path`

## Requirements
- R1: While `rst_n` is low, on the next clock edge `latch_q` and `host_rd_data` become zero.
- R2: When `rd_stb` is high at a clock edge, `latch_q` holds the full `mem_data` word sampled at that edge from the next cycle on, whatever `read_mode` is.
- R3: When `rd_stb` is low at a clock edge, `latch_q` keeps its value.
- R4: When `rd_stb` is high with `read_mode` = 0, `host_rd_data` in the next cycle equals plane `map_sel` of `mem_data`, where plane p occupies bits [8p+7:8p].
- R5: When `rd_stb` is high with `read_mode` = 1, bit i of `host_rd_data` in the next cycle is 1 exactly when, for every plane p whose `care_mask[p]` is 1, bit i of plane p equals `cmp_color[p]`.
- R6: In match mode a plane whose `care_mask` bit is 0 has no effect on the result; changing that plane's data leaves `host_rd_data` unchanged.
- R7: In match mode with `care_mask` = 0, `host_rd_data` becomes FFh.
- R8: When `rd_stb` is low at a clock edge, `host_rd_data` keeps its value, even when the mode, map index, colour, care mask or memory data change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| rd_stb | input | 1 | Host read strobe, one cycle per read |
| mem_data | input | 32 | Word from display memory, plane p in bits [8p+7:8p] |
| read_mode | input | 1 | 0 = plane byte, 1 = colour match mask |
| map_sel | input | 2 | Plane index for plane mode |
| cmp_color | input | 4 | Reference colour, bit p belongs to plane p |
| care_mask | input | 4 | Bit p = 1 includes plane p in the comparison |
| host_rd_data | output | 8 | Byte returned to the host |
| latch_q | output | 32 | Latched memory word for the write side |

## Verification
The bench builds the block with its default shape: four planes of eight pixels. At that size the colour space is only four bits wide. This makes every pairing of reference colour and care mask (256 in all) reachable against several memory words. Every map index is also swept in plane mode. Hold behaviour is checked between reads by disturbing all inputs with the strobe low. The don't-care rule is checked directly by flipping an ignored plane and comparing the two results.

// File: rtl/gcr_read_pkg.sv
package gcr_read_pkg;

  // Selects what the host read returns.
  typedef enum logic {
    RD_PLANE = 1'b0,
    RD_MATCH = 1'b1
  } rd_mode_e;

endpackage

// File: rtl/gcr_word_latch.sv
module gcr_word_latch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/gcr_plane_mux.sv
module gcr_plane_mux #(
  parameter int PLANES = 4,
  parameter int PIX_W  = 8,
  localparam int MEM_W = PLANES * PIX_W,
  localparam int SEL_W = (PLANES > 1) ? $clog2(PLANES) : 1
) (
  input  logic [MEM_W-1:0] word,
  input  logic [SEL_W-1:0] sel,
  output logic [PIX_W-1:0] byte_out
);

  logic [PIX_W-1:0] planes [PLANES];

  for (genvar p = 0; p < PLANES; p++) begin : g_split
    assign planes[p] = word[p*PIX_W +: PIX_W];
  end

  always_comb begin
    byte_out = '0;
    for (int p = 0; p < PLANES; p++) begin
      if (sel == SEL_W'(p)) byte_out = planes[p];
    end
  end

endmodule

// File: rtl/gcr_color_cmp.sv
module gcr_color_cmp #(
  parameter int PLANES = 4,
  parameter int PIX_W  = 8,
  localparam int MEM_W = PLANES * PIX_W
) (
  input  logic [MEM_W-1:0]  word,
  input  logic [PLANES-1:0] ref_color,
  input  logic [PLANES-1:0] care,
  output logic [PIX_W-1:0]  match
);

  // A pixel agrees when no cared plane differs from the reference.
  function automatic logic pix_agrees(input logic [PLANES-1:0] pix_color,
                                      input logic [PLANES-1:0] refc,
                                      input logic [PLANES-1:0] mask);
    logic [PLANES-1:0] hit;
    for (int p = 0; p < PLANES; p++) begin
      hit[p] = ~mask[p] | (pix_color[p] == refc[p]);
    end
    return &hit;
  endfunction

  for (genvar i = 0; i < PIX_W; i++) begin : g_pix
    logic [PLANES-1:0] pix_color;
    for (genvar p = 0; p < PLANES; p++) begin : g_gather
      assign pix_color[p] = word[p*PIX_W + i];
    end
    assign match[i] = pix_agrees(pix_color, ref_color, care);
  end

endmodule

// File: rtl/gcr_read_path.sv
module gcr_read_path
  import gcr_read_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int PIX_W  = 8,
  localparam int MEM_W = PLANES * PIX_W,
  localparam int SEL_W = (PLANES > 1) ? $clog2(PLANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic [MEM_W-1:0]  mem_data,
  input  logic              read_mode,
  input  logic [SEL_W-1:0]  map_sel,
  input  logic [PLANES-1:0] cmp_color,
  input  logic [PLANES-1:0] care_mask,
  output logic [PIX_W-1:0]  host_rd_data,
  output logic [MEM_W-1:0]  latch_q
);

  rd_mode_e         mode;
  logic [PIX_W-1:0] plane_byte;
  logic [PIX_W-1:0] match_mask;
  logic [PIX_W-1:0] next_rd_data;
  logic             load_evt;

  assign mode     = rd_mode_e'(read_mode);
  assign load_evt = rd_stb;

  gcr_word_latch #(.W(MEM_W)) u_latch (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load_evt),
    .d    (mem_data),
    .q    (latch_q)
  );

  gcr_plane_mux #(.PLANES(PLANES), .PIX_W(PIX_W)) u_mux (
    .word    (mem_data),
    .sel     (map_sel),
    .byte_out(plane_byte)
  );

  gcr_color_cmp #(.PLANES(PLANES), .PIX_W(PIX_W)) u_cmp (
    .word     (mem_data),
    .ref_color(cmp_color),
    .care     (care_mask),
    .match    (match_mask)
  );

  always_comb begin
    unique case (mode)
      RD_PLANE: next_rd_data = plane_byte;
      RD_MATCH: next_rd_data = match_mask;
      default:  next_rd_data = plane_byte;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        host_rd_data <= '0;
    else if (load_evt) host_rd_data <= next_rd_data;
  end

endmodule

// File: rtl/gcr_read_path_chk.sv
module gcr_read_path_chk #(
  parameter int PLANES = 4,
  parameter int PIX_W  = 8,
  localparam int MEM_W = PLANES * PIX_W,
  localparam int SEL_W = (PLANES > 1) ? $clog2(PLANES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_stb,
  input logic [MEM_W-1:0]  mem_data,
  input logic              read_mode,
  input logic [SEL_W-1:0]  map_sel,
  input logic [PLANES-1:0] care_mask,
  input logic [PIX_W-1:0]  host_rd_data,
  input logic [MEM_W-1:0]  latch_q
);

  logic [PIX_W-1:0] sel_byte;
  always_comb begin
    sel_byte = '0;
    for (int p = 0; p < PLANES; p++) begin
      if (map_sel == SEL_W'(p)) sel_byte = mem_data[p*PIX_W +: PIX_W];
    end
  end

  // R1
  rst_clears_chk: assert property (@(posedge clk)
    !rst_n |=> (latch_q == '0 && host_rd_data == '0));

  // R2
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> latch_q == $past(mem_data));

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(latch_q));

  // R4
  plane_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !read_mode) |=> host_rd_data == $past(sel_byte));

  // R7
  no_care_all_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && read_mode && care_mask == '0) |=> host_rd_data == '1);

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(host_rd_data));

endmodule

bind gcr_read_path gcr_read_path_chk #(.PLANES(PLANES), .PIX_W(PIX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_stb      (rd_stb),
  .mem_data    (mem_data),
  .read_mode   (read_mode),
  .map_sel     (map_sel),
  .care_mask   (care_mask),
  .host_rd_data(host_rd_data),
  .latch_q     (latch_q)
);

// File: tb/gcr_read_path_test.sv
module gcr_read_path_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_stb = 1'b0;
  logic [31:0] mem_data = '0;
  logic        read_mode = 1'b0;
  logic [1:0]  map_sel = '0;
  logic [3:0]  cmp_color = '0;
  logic [3:0]  care_mask = '0;
  logic [7:0]  host_rd_data;
  logic [31:0] latch_q;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  gcr_read_path uut (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .mem_data(mem_data),
    .read_mode(read_mode), .map_sel(map_sel), .cmp_color(cmp_color),
    .care_mask(care_mask), .host_rd_data(host_rd_data), .latch_q(latch_q)
  );

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected match mask: per pixel, build its colour and compare under the mask.
  function automatic logic [7:0] exp_match(input logic [31:0] m, input logic [3:0] c,
                                           input logic [3:0] k);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      logic [3:0] col;
      col = {m[24+i], m[16+i], m[8+i], m[i]};
      r[i] = (((col ^ c) & k) == 4'h0);
    end
    return r;
  endfunction

  task automatic do_read(input logic md, input logic [1:0] s, input logic [3:0] c,
                         input logic [3:0] k, input logic [31:0] m);
    @(negedge clk);
    read_mode = md; map_sel = s; cmp_color = c; care_mask = k; mem_data = m;
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic disturb_and_hold(input logic [7:0] exp_d, input logic [31:0] exp_l);
    @(negedge clk);
    mem_data = ~mem_data; read_mode = ~read_mode; map_sel = map_sel + 2'd1;
    cmp_color = ~cmp_color; care_mask = ~care_mask;
    @(negedge clk);
    check32("R8", {24'h0, host_rd_data}, {24'h0, exp_d});
    check32("R3", latch_q, exp_l);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'hA5C3_0FF0;
    pats[1] = 32'h1234_ABCD;
    pats[2] = 32'hFF00_55AA;
    pats[3] = 32'h0F1E_2D3C;

    repeat (3) @(negedge clk);
    check32("R1", latch_q, 32'h0);
    check32("R1", {24'h0, host_rd_data}, 32'h0);
    rst_n = 1'b1;

    // R4 and R2: every map index over several words
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < 4; s++) begin
        do_read(1'b0, 2'(s), 4'h0, 4'h0, pats[k]);
        check32("R4", {24'h0, host_rd_data}, (pats[k] >> (8 * s)) & 32'hFF);
        check32("R2", latch_q, pats[k]);
      end
      disturb_and_hold(host_rd_data, latch_q);
    end

    // R5, R2, R7: every colour / care pairing
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 16; c++) begin
        for (int m = 0; m < 16; m++) begin
          logic [31:0] w;
          w = pats[k] ^ (32'h0101_0101 * 32'(c));
          do_read(1'b1, 2'd0, 4'(c), 4'(m), w);
          if (m == 0) check32("R7", {24'h0, host_rd_data}, 32'hFF);
          else check32("R5", {24'h0, host_rd_data}, {24'h0, exp_match(w, 4'(c), 4'(m))});
          check32("R2", latch_q, w);
        end
      end
      disturb_and_hold(host_rd_data, latch_q);
    end

    // R6: flipping ignored planes leaves the mask alone
    for (int k = 0; k < 4; k++) begin
      logic [7:0] first;
      do_read(1'b1, 2'd0, 4'hA, 4'b0101, pats[k]);
      first = host_rd_data;
      do_read(1'b1, 2'd0, 4'hA, 4'b0101, pats[k] ^ 32'hFF00_FF00);
      check32("R6", {24'h0, host_rd_data}, {24'h0, first});
      do_read(1'b1, 2'd0, 4'h3, 4'b1000, pats[k] ^ 32'h00FF_FFFF);
      first = host_rd_data;
      do_read(1'b1, 2'd0, 4'h3, 4'b1000, pats[k]);
      check32("R6", {24'h0, host_rd_data}, {24'h0, first});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule